// File: doc/BRIEF.md
# Multi-Format PCM Serial Transmitter

This block turns parallel audio samples into serial streams for external digital-to-analog converters. Eight channels are carried on four data lanes, and each lane holds one left/right pair. From the block clock, which is the audio reference clock, the block derives three clocks. The oversampling master clock divides the reference by a programmable ratio. The bit clock runs at a quarter of the master clock. The word-select clock marks the left and right halves of each 64-slot frame. All four lanes share one bit clock and one word-select line.

Each channel has its own valid/ready sample port. Ready pulses for one cycle at the end of every frame. At that moment each channel either takes its new sample or repeats its old one and raises a sticky underrun flag. The word length can be 16, 18, 20 or 24 bits, and the justification can be I2S-style (MSB one slot late) or Sony-style (MSB on the word-select edge). Both settings are taken at the frame boundary, so a frame on the wire is never mixed.

Top module: `pcm_serial_tx`

## Requirements
- R1: The master clock has a period of 2*(cfg_mclk_div+1) block clock cycles. The bit clock period is exactly four master clock periods, and every bit clock edge coincides with a falling master clock edge.
- R2: A frame is 64 bit-clock slots. Word select is low in slots 0 to 31 (left) and high in slots 32 to 63 (right), and it only changes on a falling bit clock edge.
- R3: Lane i carries channel 2*i in the left half and channel 2*i+1 in the right half. Each slot's bit is launched on the falling bit clock edge.
- R4: With cfg_fmt = 0 (I2S-style), the sample MSB goes out in slot 1 of each half, and slot 0 is zero.
- R5: With cfg_fmt = 1 (Sony-style), the sample MSB goes out in slot 0 of each half.
- R6: cfg_wlen codes 0, 1, 2 and 3 select 16, 18, 20 and 24 bits. The top bits of the 24-bit sample are sent MSB first, the rest are dropped, and all later slots of the half carry 0.
- R7: cfg_wlen and cfg_fmt are sampled only at the frame boundary. A change mid-frame has no effect on the frame in progress.
- R8: smp_ready is high for exactly one block clock cycle, the last cycle of each frame, and a sample moves when valid and ready are both high.
- R9: A channel whose valid is low at the frame boundary repeats its previous sample and sets its underrun bit. The bit stays set until reset.
- R10: After reset, all clock outputs, sdata and underrun are 0, stored samples are 0, and the configuration is 24-bit I2S-style. Operation starts on the third clock edge after aresetn rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Audio reference clock, the block clock |
| aresetn | input | 1 | Asynchronous active-low reset |
| cfg_mclk_div | input | 8 | Master clock half-period minus one, in block clock cycles |
| cfg_wlen | input | 2 | Word length code |
| cfg_fmt | input | 1 | 0 = I2S-style, 1 = Sony-style justification |
| smp_valid | input | 8 | Per-channel sample valid |
| smp_data | input | 8x24 | Per-channel 24-bit samples, channel index is the outer dimension |
| smp_ready | output | 8 | Per-channel ready, pulsed at the frame boundary |
| underrun | output | 8 | Sticky per-channel underrun flags |
| mclk | output | 1 | Oversampling master clock (256x frame rate) |
| bclk | output | 1 | Serial bit clock (64x frame rate) |
| ws | output | 1 | Word select, low for left |
| sdata | output | 4 | Serial data, one bit per lane |

## Verification
Assertions check the clock relationships on every cycle. Bit clock edges must fall on falling master clock edges, and word select may only move on a falling bit clock edge. They also check that the ready pulse lasts a single cycle, that underrun bits never clear, that a stored sample stays put unless a valid transfer happens, and that the configuration only changes at a frame boundary. The bench's scenarios are needed for the rest, because it depends on sample values: the slot position of the MSB in each format, truncation and zero fill for each word length, lane-to-channel mapping, sample repetition on underrun, a configuration change mid-frame, and a live change of the divider.

// File: rtl/pcm_tx_pkg.sv
package pcm_tx_pkg;
  typedef enum logic [1:0] {WL16 = 2'd0, WL18 = 2'd1, WL20 = 2'd2, WL24 = 2'd3} wlen_e;
  typedef enum logic {FMT_I2S = 1'b0, FMT_SONY = 1'b1} fmt_e;

  typedef struct packed {
    wlen_e wlen;
    fmt_e  fmt;
  } frame_cfg_t;

  function automatic int wlen_bits(wlen_e w);
    case (w)
      WL16:    return 16;
      WL18:    return 18;
      WL20:    return 20;
      default: return 24;
    endcase
  endfunction
endpackage

// File: rtl/pcm_rst_sync.sv
module pcm_rst_sync (
  input  logic clk,
  input  logic aresetn,
  output logic rst_n
);
  logic [1:0] sync_q, sync_d;

  always_comb sync_d = {sync_q[0], 1'b1};

  always_ff @(posedge clk or negedge aresetn) begin
    if (!aresetn) sync_q <= '0;
    else          sync_q <= sync_d;
  end

  assign rst_n = sync_q[1];
endmodule

// File: rtl/pcm_tick_gen.sv
module pcm_tick_gen #(
  parameter int DIV_W = 8,
  parameter int SUB_W = 3,
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  output logic [CNT_W-1:0] cnt_nxt,
  output logic             frame_end,
  output logic             mclk,
  output logic             bclk,
  output logic             ws
);
  logic [DIV_W-1:0] pre_q, pre_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             tick;
  logic             mclk_q, bclk_q, ws_q;

  always_comb begin
    tick  = (pre_q >= div);
    pre_d = tick ? '0 : pre_q + 1'b1;
    cnt_d = tick ? cnt_q + 1'b1 : cnt_q;
  end

  assign frame_end = tick && (cnt_q == '1);
  assign cnt_nxt   = cnt_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      cnt_q  <= '0;
      mclk_q <= 1'b0;
      bclk_q <= 1'b0;
      ws_q   <= 1'b0;
    end else begin
      pre_q  <= pre_d;
      cnt_q  <= cnt_d;
      mclk_q <= cnt_d[0];
      bclk_q <= cnt_d[SUB_W-1];
      ws_q   <= cnt_d[CNT_W-1];
    end
  end

  assign mclk = mclk_q;
  assign bclk = bclk_q;
  assign ws   = ws_q;

  // R1
  bclk_on_mclk_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bclk_q != $past(bclk_q)) |-> $fell(mclk_q));

  // R2
  ws_on_bclk_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ws_q != $past(ws_q)) |-> $fell(bclk_q));

  // R8
  ready_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> !frame_end);
endmodule

// File: rtl/pcm_frame_latch.sv
module pcm_frame_latch
  import pcm_tx_pkg::*;
#(
  parameter int N_CH  = 8,
  parameter int SMP_W = 24
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        frame_end,
  input  logic [N_CH-1:0]             valid,
  input  logic [N_CH-1:0][SMP_W-1:0]  data,
  input  logic [1:0]                  wlen_in,
  input  logic                        fmt_in,
  output logic [N_CH-1:0][SMP_W-1:0]  smp_nxt,
  output frame_cfg_t                  cfg_nxt,
  output logic [N_CH-1:0]             uflow
);
  logic [N_CH-1:0][SMP_W-1:0] smp_q, smp_d;
  logic [N_CH-1:0]            uf_q, uf_d;
  frame_cfg_t                 cfg_q, cfg_d;

  always_comb begin
    smp_d = smp_q;
    uf_d  = uf_q;
    cfg_d = cfg_q;
    if (frame_end) begin
      cfg_d.wlen = wlen_e'(wlen_in);
      cfg_d.fmt  = fmt_e'(fmt_in);
      for (int ch = 0; ch < N_CH; ch++) begin
        if (valid[ch]) smp_d[ch] = data[ch];
        else           uf_d[ch]  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_q <= '0;
      uf_q  <= '0;
      cfg_q <= '{wlen: WL24, fmt: FMT_I2S};
    end else begin
      smp_q <= smp_d;
      uf_q  <= uf_d;
      cfg_q <= cfg_d;
    end
  end

  assign smp_nxt = smp_d;
  assign cfg_nxt = cfg_d;
  assign uflow   = uf_q;

  // R9
  underrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((uf_q & $past(uf_q)) == $past(uf_q)));

  // R7
  cfg_frame_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_end |=> $stable(cfg_q));

  for (genvar g = 0; g < N_CH; g++) begin : g_hold
    // R9
    sample_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(frame_end && valid[g]) |=> $stable(smp_q[g]));
  end
endmodule

// File: rtl/pcm_lane_ser.sv
module pcm_lane_ser
  import pcm_tx_pkg::*;
#(
  parameter int SMP_W  = 24,
  parameter int SUB_W  = 3,
  parameter int SLOT_W = 5,
  parameter int CNT_W  = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  cnt_nxt,
  input  logic [SMP_W-1:0]  left,
  input  logic [SMP_W-1:0]  right,
  input  frame_cfg_t        cfg_nxt,
  output logic              sd
);
  logic [SLOT_W-1:0] slot;
  logic [SMP_W-1:0]  word;
  logic              sd_d, sd_q;
  int                k;

  always_comb begin
    slot = cnt_nxt[CNT_W-2:SUB_W];
    word = cnt_nxt[CNT_W-1] ? right : left;
    k    = int'(slot) - ((cfg_nxt.fmt == FMT_I2S) ? 1 : 0);
    sd_d = 1'b0;
    if (k >= 0 && k < wlen_bits(cfg_nxt.wlen) && k < SMP_W)
      sd_d = word[SMP_W-1-k];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sd_q <= 1'b0;
    else        sd_q <= sd_d;
  end

  assign sd = sd_q;
endmodule

// File: rtl/pcm_serial_tx.sv
module pcm_serial_tx
  import pcm_tx_pkg::*;
#(
  parameter int N_LANES      = 4,
  parameter int SMP_W        = 24,
  parameter int DIV_W        = 8,
  parameter int SLOTS_HALF   = 32,
  parameter int MCLK_PER_BIT = 4
) (
  input  logic                                clk,
  input  logic                                aresetn,
  input  logic [DIV_W-1:0]                    cfg_mclk_div,
  input  logic [1:0]                          cfg_wlen,
  input  logic                                cfg_fmt,
  input  logic [2*N_LANES-1:0]                smp_valid,
  input  logic [2*N_LANES-1:0][SMP_W-1:0]     smp_data,
  output logic [2*N_LANES-1:0]                smp_ready,
  output logic [2*N_LANES-1:0]                underrun,
  output logic                                mclk,
  output logic                                bclk,
  output logic                                ws,
  output logic [N_LANES-1:0]                  sdata
);
  localparam int N_CH   = 2 * N_LANES;
  localparam int SUB_W  = $clog2(2 * MCLK_PER_BIT);
  localparam int SLOT_W = $clog2(SLOTS_HALF);
  localparam int CNT_W  = SUB_W + SLOT_W + 1;

  logic                       rst_n;
  logic [CNT_W-1:0]           cnt_nxt;
  logic                       frame_end;
  logic [N_CH-1:0][SMP_W-1:0] smp_nxt;
  frame_cfg_t                 cfg_nxt;

  pcm_rst_sync u_rst (.clk(clk), .aresetn(aresetn), .rst_n(rst_n));

  pcm_tick_gen #(.DIV_W(DIV_W), .SUB_W(SUB_W), .CNT_W(CNT_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .div(cfg_mclk_div), .cnt_nxt(cnt_nxt),
    .frame_end(frame_end), .mclk(mclk), .bclk(bclk), .ws(ws));

  pcm_frame_latch #(.N_CH(N_CH), .SMP_W(SMP_W)) u_latch (
    .clk(clk), .rst_n(rst_n), .frame_end(frame_end), .valid(smp_valid),
    .data(smp_data), .wlen_in(cfg_wlen), .fmt_in(cfg_fmt),
    .smp_nxt(smp_nxt), .cfg_nxt(cfg_nxt), .uflow(underrun));

  for (genvar ln = 0; ln < N_LANES; ln++) begin : g_lane
    pcm_lane_ser #(.SMP_W(SMP_W), .SUB_W(SUB_W), .SLOT_W(SLOT_W), .CNT_W(CNT_W)) u_ser (
      .clk(clk), .rst_n(rst_n), .cnt_nxt(cnt_nxt),
      .left(smp_nxt[2*ln]), .right(smp_nxt[2*ln+1]),
      .cfg_nxt(cfg_nxt), .sd(sdata[ln]));
  end

  assign smp_ready = {N_CH{frame_end}};
endmodule

// File: tb/pcm_serial_tx_test.sv
module pcm_serial_tx_test;
  logic             clk = 1'b0;
  logic             aresetn = 1'b1;
  logic [7:0]       cfg_mclk_div = 8'd0;
  logic [1:0]       cfg_wlen = 2'd3;
  logic             cfg_fmt = 1'b0;
  logic [7:0]       smp_valid = '0;
  logic [7:0][23:0] smp_data = '0;
  logic [7:0]       smp_ready, underrun;
  logic             mclk, bclk, ws;
  logic [3:0]       sdata;

  pcm_serial_tx uut (.*);

  always #2.5 clk = ~clk;

  int compared = 0, mismatched = 0, cycles = 0;
  bit cmp_en = 0;

  // behavioural reference state
  int         m_pre = 0, m_cnt = 0, m_wl = 24, m_fmt = 0, rs = 0;
  logic [23:0] m_smp [8];
  bit          m_uf  [8];

  function automatic int code_bits(logic [1:0] c);
    return (c == 0) ? 16 : (c == 1) ? 18 : (c == 2) ? 20 : 24;
  endfunction

  task automatic model_reset();
    m_pre = 0; m_cnt = 0; m_wl = 24; m_fmt = 0;
    for (int c = 0; c < 8; c++) begin m_smp[c] = '0; m_uf[c] = 0; end
  endtask

  initial model_reset();

  always @(posedge clk) begin
    bit active;
    active = (rs == 2);
    if (!aresetn) begin
      rs = 0;
      model_reset();
    end else begin
      if (rs < 2) rs++;
      if (active) begin
        if (m_pre >= int'(cfg_mclk_div)) begin
          if (m_cnt == 511) begin
            for (int c = 0; c < 8; c++)
              if (smp_valid[c]) m_smp[c] = smp_data[c]; else m_uf[c] = 1;
            m_wl = code_bits(cfg_wlen);
            m_fmt = int'(cfg_fmt);
          end
          m_pre = 0;
          m_cnt = (m_cnt + 1) % 512;
        end else m_pre++;
      end
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s at cycle %0d: actual %h expected %h", req, cycles, act, exp);
    end
  endtask

  function automatic logic exp_bit(int lane);
    int half, slot, k;
    logic [23:0] w;
    half = m_cnt / 256;
    slot = (m_cnt / 8) % 32;
    w = m_smp[2*lane + half];
    k = slot - ((m_fmt == 0) ? 1 : 0);
    return (k >= 0 && k < m_wl) ? w[23-k] : 1'b0;
  endfunction

  always @(negedge clk) begin
    cycles++;
    if (cmp_en) begin
      logic [7:0] er, eu;
      er = (rs == 2 && m_pre >= int'(cfg_mclk_div) && m_cnt == 511) ? 8'hFF : 8'h00;
      for (int c = 0; c < 8; c++) eu[c] = m_uf[c];
      chk("R1 mclk", 32'(mclk), 32'(m_cnt % 2));
      chk("R1 bclk", 32'(bclk), 32'((m_cnt / 4) % 2));
      chk("R2 ws", 32'(ws), 32'(m_cnt / 256));
      for (int l = 0; l < 4; l++)
        chk($sformatf("R3,R4,R5,R6,R7 sdata lane %0d", l), 32'(sdata[l]), 32'(exp_bit(l)));
      chk("R8 smp_ready", 32'(smp_ready), 32'(er));
      chk("R9 underrun", 32'(underrun), 32'(eu));
    end
    if (cycles > 150000) begin
      mismatched++;
      $display("FAIL watchdog expired at cycle %0d: actual hung expected done", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic wait_cycles(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // present samples, change config after 'dly' cycles, wait for the boundary transfer
  task automatic frame(logic [7:0] mask, logic [1:0] wl, logic fmt, int dly);
    @(negedge clk); #1;
    for (int c = 0; c < 8; c++) smp_data[c] = 24'($urandom);
    smp_valid = mask;
    wait_cycles(dly);
    #1;
    cfg_wlen = wl;
    cfg_fmt = fmt;
    do @(negedge clk); while (!smp_ready[0]);
    @(posedge clk); #1;
    smp_valid = '0;
  endtask

  task automatic do_reset();
    @(negedge clk); #1;
    aresetn = 1'b0;
    wait_cycles(4);
    // R10: outputs at rest while reset is held
    chk("R10 reset outputs", {26'd0, mclk, bclk, ws, 3'd0} | 32'(sdata) | 32'(underrun), 32'd0);
    #1;
    aresetn = 1'b1;
  endtask

  initial begin
    #2;
    aresetn = 1'b0;
    wait_cycles(3);
    cmp_en = 1;
    do_reset();
    // main traffic: 24-bit I2S, then Sony, then each short length (R4, R5, R6)
    frame(8'hFF, 2'd3, 1'b0, 0);
    frame(8'hFF, 2'd3, 1'b0, 0);
    frame(8'hFF, 2'd3, 1'b1, 0);
    frame(8'hFF, 2'd0, 1'b1, 0);
    frame(8'hFF, 2'd0, 1'b0, 0);
    frame(8'hFF, 2'd1, 1'b0, 0);
    frame(8'hFF, 2'd2, 1'b1, 0);
    // R7: config changes mid-frame
    frame(8'hFF, 2'd1, 1'b1, 200);
    frame(8'hFF, 2'd3, 1'b0, 300);
    // R9: partial underrun, then full underrun
    frame(8'hA5, 2'd3, 1'b1, 0);
    frame(8'h00, 2'd2, 1'b0, 0);
    frame(8'hFF, 2'd3, 1'b0, 0);
    // R1: other divider ratios
    cfg_mclk_div = 8'd2;
    frame(8'hFF, 2'd3, 1'b1, 0);
    cfg_mclk_div = 8'd1;
    frame(8'hFF, 2'd0, 1'b0, 0);
    cfg_mclk_div = 8'd0;
    // R10: reset clears underrun and stored samples mid-run
    wait_cycles(100);
    do_reset();
    frame(8'hFF, 2'd3, 1'b0, 0);
    wait_cycles(600);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule